// File: doc/BRIEF.md
# Logical Shifter with Selectable Oversized-Count Handling

This unit performs a logical left or right shift of a parameterized data word and registers the outcome. Each operation gives a shifted word and a carry bit. The carry is the last bit that left the word during the shift.

The shift count input is wider than the bits needed to address a position in the word. A mode input therefore sets what happens when the count reaches or passes the word width. There are two modes:

- **Wrapping mode.** Only the low log2(W) bits of the count are used, so the count is taken modulo the width.
- **Zero-fill mode.** The operand behaves as if endless zeros sit beyond it. Counts at or above the width clear the word, and the carry stays well defined.

A pipeline that must match either convention places one registered stage of this unit in its datapath. A new operation is presented on any cycle by raising the strobe.

Top module: `shift_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released with no operation issued, out_valid, out_data and out_carry are all 0.
- R2: out_valid equals in_valid delayed by one clock. The result of an operation issued in one cycle appears on out_data and out_carry after the next rising edge.
- R3: While in_valid is 0, out_data and out_carry keep their previous values.
- R4: A count of 0 returns the operand unchanged with carry 0, in both modes and both directions.
- R5: In wrapping mode (in_zext = 0), only count bits [log2(W)-1:0] matter, giving bits [4:0] for W = 32. A count equal to W therefore passes the operand through unchanged with carry 0, and a count of 200 acts as a count of 8.
- R6: For a left shift (in_left = 1) in wrapping mode with effective count e ≥ 1, the result is the operand shifted left by e and the carry is operand bit W−e.
- R7: For a right shift (in_left = 0) in wrapping mode with effective count e ≥ 1, the result is the operand shifted right by e and the carry is operand bit e−1.
- R8: For a left shift in zero-fill mode (in_zext = 1) with count c, where 1 ≤ c ≤ W, the result is the operand shifted left by c and the carry is operand bit W−c. At c = W the result is 0 and the carry is operand bit 0. For c > W, both the result and the carry are 0.
- R9: For a right shift in zero-fill mode with count c, where 1 ≤ c ≤ W, the result is the operand shifted right by c and the carry is operand bit c−1. At c = W the result is 0 and the carry is operand bit W−1. For c > W, both the result and the carry are 0.
- R10: Shifting the value 1 left by W/2, and then shifting that result left by W/2 again, gives 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_data | input | W | Operand |
| in_count | input | CW | Shift count |
| in_left | input | 1 | 1 = shift left, 0 = shift right |
| in_zext | input | 1 | 1 = zero-fill mode, 0 = wrapping mode |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | W | Shifted word |
| out_carry | output | 1 | Last bit shifted out |

## Verification
The bench targets the count boundaries 0, 1, W−1, W, W+1 and 200 in both modes and both directions.

Each boundary catches a specific fault:

- A design that does not mask the count in wrapping mode clears the word at a count of W instead of passing it through.
- A design that masks the count in zero-fill mode returns the operand unchanged where it should return zero.
- An off-by-one in the carry index shows up at a count of 1 or W as the wrong neighbouring bit.
- A carry left undefined past the width shows up as a stray 1 at a count of W+1.

Idle cycles with changing inputs expose a result register that loads without the strobe.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W  = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [CW-1:0] in_count,
  input  logic          in_left,
  input  logic          in_zext,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          out_carry
);
  localparam int LW = $clog2(W);

  logic [CW-1:0] eff;
  logic [W:0]    lt, rt;

  assign eff = in_zext ? in_count : CW'(in_count[LW-1:0]);
  assign lt  = {1'b0, in_data} << eff;
  assign rt  = {in_data, 1'b0} >> eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_carry <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= in_left ? lt[W-1:0] : rt[W:1];
        out_carry <= in_left ? lt[W] : rt[0];
      end
    end
  end

  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_carry)));
  p_zero_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_count == '0) |=> (out_data == $past(in_data) && !out_carry));
  p_wrap_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_zext && in_count == CW'(W)) |=> (out_data == $past(in_data) && !out_carry));
  p_zfill_left_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zext && in_left && in_count == CW'(W)) |=> (out_data == '0 && out_carry == $past(in_data[0])));
  p_zfill_right_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zext && !in_left && in_count == CW'(W)) |=> (out_data == '0 && out_carry == $past(in_data[W-1])));
  p_zfill_beyond_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_zext && int'(in_count) > W) |=> (out_data == '0 && !out_carry));
endmodule

// File: tb/shift_unit_test.sv
module shift_unit_test;
  localparam int W  = 32;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic [CW-1:0] in_count = '0;
  logic          in_left = 1'b0;
  logic          in_zext = 1'b0;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic          out_carry;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] exp_data = '0;
  logic         exp_carry = 1'b0;
  logic         exp_valid = 1'b0;
  string        exp_tag = "R1";

  always #2 clk = ~clk;

  shift_unit #(.W(W), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_count(in_count), .in_left(in_left), .in_zext(in_zext),
    .out_valid(out_valid), .out_data(out_data), .out_carry(out_carry)
  );

  task automatic model(input logic [W-1:0] d, input int c, input logic l, input logic z,
                       output logic [W-1:0] r, output logic cy);
    int n;
    n = z ? c : (c % W);
    r = d;
    cy = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (l) begin
        cy = r[W-1];
        r = r << 1;
      end else begin
        cy = r[0];
        r = r >> 1;
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid || out_data !== exp_data || out_carry !== exp_carry) begin
      fails++;
      $display("FAIL %s: valid/data/carry actual %0b/%h/%0b expected %0b/%h/%0b",
               exp_tag, out_valid, out_data, out_carry, exp_valid, exp_data, exp_carry);
    end
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input int c,
                      input logic l, input logic z, input string tag);
    logic [W-1:0] r;
    logic cy;
    @(negedge clk);
    compare();
    in_valid = v;
    in_data  = d;
    in_count = CW'(c);
    in_left  = l;
    in_zext  = z;
    exp_valid = v;
    exp_tag = tag;
    if (v) begin
      model(d, c, l, z, r, cy);
      exp_data  = r;
      exp_carry = cy;
    end
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] mid;
    int cnts [6] = '{0, 1, W-1, W, W+1, 200};
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    step(0, 32'hDEAD_BEEF, 5, 1, 0, "R1");
    step(0, 32'h1234_5678, 3, 0, 1, "R1");

    step(1, 32'hA5A5_0F0F, 0, 1, 0, "R4");
    step(1, 32'hA5A5_0F0F, 0, 0, 0, "R4");
    step(1, 32'h8000_0001, 0, 1, 1, "R4");
    step(1, 32'h8000_0001, 0, 0, 1, "R4");

    step(1, 32'hCAFE_F00D, W, 1, 0, "R5");
    step(1, 32'hCAFE_F00D, W, 0, 0, "R5");
    step(1, 32'hCAFE_F00D, 200, 1, 0, "R5");
    step(1, 32'hCAFE_F00D, 200, 0, 0, "R5");
    step(1, 32'h0000_00FF, 37, 1, 0, "R5");

    step(1, 32'h8000_0000, 1, 1, 0, "R6");
    step(1, 32'h0F00_0000, 5, 1, 0, "R6");
    step(1, 32'h0000_0001, W-1, 1, 0, "R6");
    step(1, 32'h0000_0001, 1, 0, 0, "R7");
    step(1, 32'h0000_00F0, 5, 0, 0, "R7");
    step(1, 32'h8000_0000, W-1, 0, 0, "R7");

    step(1, 32'h8000_0000, 1, 1, 1, "R8");
    step(1, 32'h0000_0001, W, 1, 1, "R8");
    step(1, 32'hFFFF_FFFF, W+1, 1, 1, "R8");
    step(1, 32'hFFFF_FFFF, 200, 1, 1, "R8");
    step(1, 32'h0000_0001, 1, 0, 1, "R9");
    step(1, 32'h8000_0000, W, 0, 1, "R9");
    step(1, 32'hFFFF_FFFF, W+1, 0, 1, "R9");
    step(1, 32'hFFFF_FFFF, 200, 0, 1, "R9");

    for (int m = 0; m < 4; m++)
      foreach (cnts[k])
        step(1, 32'h9E37_79B9 ^ (32'h1 << k), cnts[k], m[0], m[1], m[1] ? (m[0] ? "R8" : "R9") : (m[0] ? "R6" : "R7"));

    step(0, 32'hFFFF_FFFF, 3, 1, 1, "R3");
    step(0, 32'h0000_0000, 9, 0, 0, "R3");
    step(1, 32'h0000_0055, 4, 0, 1, "R2");
    step(1, 32'h0000_0055, 4, 1, 1, "R2");

    for (int z = 0; z < 2; z++) begin
      step(1, 32'h1, W/2, 1, z[0], "R10");
      step(0, 32'h0, 0, 0, 0, "R10");
      mid = out_data;
      step(1, mid, W/2, 1, z[0], "R10");
      step(0, 32'h0, 0, 0, 0, "R10");
      checks++;
      if (out_data !== '0) begin
        fails++;
        $display("FAIL R10: actual %h expected 0", out_data);
      end
    end

    for (int i = 0; i < 200; i++)
      step(1, $urandom, $urandom_range(0, 255), 1'($urandom), 1'($urandom), "R6");
    step(0, 32'h0, 0, 0, 0, "R3");
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule